// File: doc/BRIEF.md
# Two-Point Pixel Corrector with Three-Stream Join

This block corrects the fixed-pattern non-uniformity of a sensor by applying a per-pixel gain and offset to every raw pixel. Three separate streams feed it: raw pixels, gain coefficients and offset coefficients. Each stream can come from its own DMA channel, so the three have no guaranteed timing relation. A join stage takes one beat from all three streams in the same cycle, and only when all three are valid and the pipeline can move. This throttles the streams together and keeps each pixel paired with its own coefficients.

The paired beat passes through a short multiply-add pipeline. A two-entry skid register at the output keeps one beat per cycle flowing under backpressure. The end-of-line and start-of-frame markers travel with the pixel. A bypass control forwards the raw pixel unchanged, so the corrected and uncorrected images can be compared. A sticky flag reports when the end-of-line marker of a coefficient stream disagrees with that of the pixel stream.

Top module: `twopoint_corrector`

## Requirements
- R1: While reset is asserted and until the first accepted beat, m_tvalid, tlast_err and all three tready outputs are low.
- R2: The three tready outputs are always equal. They are high only in a cycle where all three tvalid inputs are high, so one beat is taken from every stream together.
- R3: Outside bypass, the output is offset + round(pixel × gain). The pixel is 14-bit unsigned. The gain is 16-bit unsigned with 14 fraction bits. The offset is 16-bit two's complement. Rounding adds 2^13 to the product before the 14 fraction bits are dropped, so halves round up.
- R4: The corrected sum is clamped to the 16-bit two's complement range [-32768, 32767], and m_tdata is written in that encoding.
- R5: When bypass is high in the cycle a beat is accepted, that beat's output is the pixel zero-extended to 16 bits. Its coefficients are still consumed.
- R6: Each accepted triple yields exactly one output beat, in acceptance order, whatever the input gaps and output stalls.
- R7: While m_tvalid is high and m_tready is low, m_tvalid stays high and m_tdata, m_tlast and m_tuser do not change.
- R8: With all inputs always valid and m_tready always high, a triple is accepted in every cycle.
- R9: When the output is not stalled, a beat accepted on one clock edge is presented on m_tvalid right after the second following edge.
- R10: m_tlast and m_tuser of each output beat are the pixel stream's tlast and tuser of that beat. The coefficient streams' tlast never reaches the output.
- R11: tlast_err goes high on the edge after a triple is accepted whose gain or offset tlast differs from the pixel tlast. It then stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bypass | input | 1 | Forward raw pixel instead of corrected value, sampled per beat |
| s_pix_tdata | input | 14 | Raw pixel |
| s_pix_tvalid | input | 1 | Pixel beat valid |
| s_pix_tready | output | 1 | Pixel beat accepted |
| s_pix_tlast | input | 1 | End of line |
| s_pix_tuser | input | 1 | Start of frame |
| s_gain_tdata | input | 16 | Gain, unsigned, 14 fraction bits |
| s_gain_tvalid | input | 1 | Gain beat valid |
| s_gain_tready | output | 1 | Gain beat accepted |
| s_gain_tlast | input | 1 | Gain stream end of line |
| s_off_tdata | input | 16 | Offset, two's complement |
| s_off_tvalid | input | 1 | Offset beat valid |
| s_off_tready | output | 1 | Offset beat accepted |
| s_off_tlast | input | 1 | Offset stream end of line |
| m_tdata | output | 16 | Corrected pixel, two's complement |
| m_tvalid | output | 1 | Output beat valid |
| m_tready | input | 1 | Downstream accepts |
| m_tlast | output | 1 | End of line, from pixel stream |
| m_tuser | output | 1 | Start of frame, from pixel stream |
| tlast_err | output | 1 | Sticky line-marker mismatch flag |

## Verification
The bench drives the three inputs with independent random gaps. It holds each tvalid until that beat is taken, so a join that let one stream run ahead would pair pixels with the wrong coefficients and produce wrong values. Random output stalls, including long ones, exercise the skid register. A skid that lost or repeated a beat would leave the scoreboard misaligned or not drained. Directed beats cover the largest product with the largest offset, where a missing clamp would wrap to a negative value. They also cover an exact half-LSB product, which shows truncation in place of rounding, and a zero gain with the most negative offset. Bypass toggles every few beats, so a bypass bit not carried with its beat would misroute neighbouring pixels. One coefficient line marker is flipped, and later clean traffic confirms that the error flag neither stays low nor clears.

// File: rtl/tpc_pkg.sv
package tpc_pkg;

  // Per-beat sideband carried alongside the pixel through the pipeline
  typedef struct packed {
    logic eol;    // end of line, from the pixel stream
    logic sof;    // start of frame, from the pixel stream
    logic pass;   // bypass selected for this beat
  } tpc_side_t;

endpackage

// File: rtl/tpc_rst_sync.sv
module tpc_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;

endmodule

// File: rtl/tpc_join.sv
module tpc_join #(
  parameter int NUM = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NUM-1:0] valid,
  input  logic [NUM-1:0] last,
  input  logic           adv_en,
  output logic [NUM-1:0] ready,
  output logic           fire,
  output logic           last_err
);

  logic all_valid;
  logic mismatch;
  logic err_d;
  logic err_q;

  // Next-state logic
  always_comb begin
    all_valid = &valid;
    fire      = all_valid & adv_en;
    ready     = {NUM{fire}};
    // markers agree when all set or all clear
    mismatch  = fire & ~((&last) | ~(|last));
    err_d     = err_q | mismatch;
  end

  // State register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_q <= 1'b0;
    end else begin
      err_q <= err_d;
    end
  end

  assign last_err = err_q;

endmodule

// File: rtl/tpc_mac.sv
module tpc_mac
  import tpc_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int OFF_W  = 16,
  parameter int OUT_W  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv_en,
  input  logic             in_fire,
  input  logic [PIX_W-1:0] in_pix,
  input  logic [GAIN_W-1:0] in_gain,
  input  logic [OFF_W-1:0] in_off,
  input  tpc_side_t        in_side,
  output logic             out_valid,
  output logic [OUT_W-1:0] out_data,
  output tpc_side_t        out_side
);

  localparam int PROD_W = PIX_W + GAIN_W;
  localparam int RND_W  = PROD_W + 1;
  localparam int SUM_A  = (RND_W + 1 > OFF_W) ? RND_W + 1 : OFF_W;
  localparam int SUM_W  = SUM_A + 1;
  localparam logic signed [SUM_W-1:0] SAT_HI =
    {{(SUM_W-OUT_W+1){1'b0}}, {(OUT_W-1){1'b1}}};
  localparam logic signed [SUM_W-1:0] SAT_LO =
    {{(SUM_W-OUT_W+1){1'b1}}, {(OUT_W-1){1'b0}}};

  // Stage 1: captured operands
  logic              v1_q, v1_d;
  logic [PIX_W-1:0]  pix1_q;
  logic [GAIN_W-1:0] gain1_q;
  logic [OFF_W-1:0]  off1_q;
  tpc_side_t         side1_q;

  // Stage 2: rounded product
  logic              v2_q, v2_d;
  logic [RND_W-1:0]  rnd2_q, rnd2_d;
  logic [PIX_W-1:0]  pix2_q;
  logic [OFF_W-1:0]  off2_q;
  tpc_side_t         side2_q;

  logic [PROD_W-1:0] prod;
  logic signed [SUM_W-1:0] corr_sum;
  logic signed [SUM_W-1:0] pre_sat;

  // Valid chain next state
  always_comb begin
    v1_d = in_fire;
    v2_d = v1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v1_q <= 1'b0;
      v2_q <= 1'b0;
    end else if (adv_en) begin
      v1_q <= v1_d;
      v2_q <= v2_d;
    end
  end

  // Stage 1 data: loaded only on an accepted beat
  always_ff @(posedge clk) begin
    if (in_fire) begin
      pix1_q  <= in_pix;
      gain1_q <= in_gain;
      off1_q  <= in_off;
      side1_q <= in_side;
    end
  end

  assign prod = PROD_W'(pix1_q) * PROD_W'(gain1_q);

  // Rounding variant chosen by the fraction width
  generate
    if (FRAC > 0) begin : g_round
      always_comb begin
        rnd2_d = ({1'b0, prod} + (RND_W)'(1) * (RND_W)'(2 ** (FRAC - 1))) >> FRAC;
      end
    end else begin : g_whole
      always_comb begin
        rnd2_d = {1'b0, prod};
      end
    end
  endgenerate

  // Stage 2 data
  always_ff @(posedge clk) begin
    if (adv_en && v1_q) begin
      rnd2_q  <= rnd2_d;
      pix2_q  <= pix1_q;
      off2_q  <= off1_q;
      side2_q <= side1_q;
    end
  end

  // Final add, bypass select and clamp feed the output register directly
  always_comb begin
    corr_sum = $signed({{(SUM_W-RND_W){1'b0}}, rnd2_q})
             + $signed({{(SUM_W-OFF_W){off2_q[OFF_W-1]}}, off2_q});
    if (side2_q.pass) begin
      pre_sat = $signed({{(SUM_W-PIX_W){1'b0}}, pix2_q});
    end else begin
      pre_sat = corr_sum;
    end
    if (pre_sat > SAT_HI) begin
      out_data = SAT_HI[OUT_W-1:0];
    end else if (pre_sat < SAT_LO) begin
      out_data = SAT_LO[OUT_W-1:0];
    end else begin
      out_data = pre_sat[OUT_W-1:0];
    end
  end

  assign out_valid = v2_q;
  assign out_side  = side2_q;

endmodule

// File: rtl/tpc_skid.sv
module tpc_skid #(
  parameter int W = 18
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] in_data,
  output logic         in_ready,
  output logic         out_valid,
  output logic [W-1:0] out_data,
  input  logic         out_ready
);

  logic         main_v_q, main_v_d;
  logic         spare_v_q, spare_v_d;
  logic [W-1:0] main_q, main_d;
  logic [W-1:0] spare_q, spare_d;
  logic         push, pop;

  // Next-state logic
  always_comb begin
    in_ready  = ~spare_v_q;
    push      = in_valid & in_ready;
    pop       = main_v_q & out_ready;
    main_v_d  = main_v_q;
    spare_v_d = spare_v_q;
    main_d    = main_q;
    spare_d   = spare_q;
    if (spare_v_q) begin
      if (pop) begin
        main_d    = spare_q;
        spare_v_d = 1'b0;
      end
    end else if (push) begin
      if (!main_v_q || pop) begin
        main_d   = in_data;
        main_v_d = 1'b1;
      end else begin
        spare_d   = in_data;
        spare_v_d = 1'b1;
      end
    end else if (pop) begin
      main_v_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      main_v_q  <= 1'b0;
      spare_v_q <= 1'b0;
    end else begin
      main_v_q  <= main_v_d;
      spare_v_q <= spare_v_d;
    end
  end

  always_ff @(posedge clk) begin
    main_q  <= main_d;
    spare_q <= spare_d;
  end

  assign out_valid = main_v_q;
  assign out_data  = main_q;

endmodule

// File: rtl/twopoint_corrector.sv
module twopoint_corrector
  import tpc_pkg::*;
#(
  parameter int PIX_W  = 14,
  parameter int GAIN_W = 16,
  parameter int FRAC   = 14,
  parameter int OFF_W  = 16,
  parameter int OUT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bypass,
  input  logic [PIX_W-1:0]  s_pix_tdata,
  input  logic              s_pix_tvalid,
  output logic              s_pix_tready,
  input  logic              s_pix_tlast,
  input  logic              s_pix_tuser,
  input  logic [GAIN_W-1:0] s_gain_tdata,
  input  logic              s_gain_tvalid,
  output logic              s_gain_tready,
  input  logic              s_gain_tlast,
  input  logic [OFF_W-1:0]  s_off_tdata,
  input  logic              s_off_tvalid,
  output logic              s_off_tready,
  input  logic              s_off_tlast,
  output logic [OUT_W-1:0]  m_tdata,
  output logic              m_tvalid,
  input  logic              m_tready,
  output logic              m_tlast,
  output logic              m_tuser,
  output logic              tlast_err
);

  localparam int NUM_IN = 3;
  localparam int PAY_W  = OUT_W + 2;

  logic              srst_n;
  logic              adv_en;
  logic              fire;
  logic              skid_in_ready;
  logic [NUM_IN-1:0] join_ready;
  tpc_side_t         side_in;
  logic              mac_valid;
  logic [OUT_W-1:0]  mac_data;
  tpc_side_t         mac_side;
  logic [PAY_W-1:0]  skid_in;
  logic [PAY_W-1:0]  skid_out;

  tpc_rst_sync i_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  // Pipeline moves only out of reset and while the skid has room
  assign adv_en = srst_n & skid_in_ready;

  tpc_join #(.NUM(NUM_IN)) i_join (
    .clk      (clk),
    .rst_n    (srst_n),
    .valid    ({s_off_tvalid, s_gain_tvalid, s_pix_tvalid}),
    .last     ({s_off_tlast, s_gain_tlast, s_pix_tlast}),
    .adv_en   (adv_en),
    .ready    (join_ready),
    .fire     (fire),
    .last_err (tlast_err)
  );

  assign s_pix_tready  = join_ready[0];
  assign s_gain_tready = join_ready[1];
  assign s_off_tready  = join_ready[2];

  always_comb begin
    side_in.eol  = s_pix_tlast;
    side_in.sof  = s_pix_tuser;
    side_in.pass = bypass;
  end

  tpc_mac #(
    .PIX_W  (PIX_W),
    .GAIN_W (GAIN_W),
    .FRAC   (FRAC),
    .OFF_W  (OFF_W),
    .OUT_W  (OUT_W)
  ) i_mac (
    .clk       (clk),
    .rst_n     (srst_n),
    .adv_en    (adv_en),
    .in_fire   (fire),
    .in_pix    (s_pix_tdata),
    .in_gain   (s_gain_tdata),
    .in_off    (s_off_tdata),
    .in_side   (side_in),
    .out_valid (mac_valid),
    .out_data  (mac_data),
    .out_side  (mac_side)
  );

  assign skid_in = {mac_data, mac_side.eol, mac_side.sof};

  tpc_skid #(.W(PAY_W)) i_skid (
    .clk       (clk),
    .rst_n     (srst_n),
    .in_valid  (mac_valid),
    .in_data   (skid_in),
    .in_ready  (skid_in_ready),
    .out_valid (m_tvalid),
    .out_data  (skid_out),
    .out_ready (m_tready)
  );

  assign m_tdata = skid_out[PAY_W-1:2];
  assign m_tlast = skid_out[1];
  assign m_tuser = skid_out[0];

endmodule

// File: rtl/tpc_checker.sv
module tpc_checker #(
  parameter int OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             s_pix_tvalid,
  input logic             s_pix_tready,
  input logic             s_pix_tlast,
  input logic             s_gain_tvalid,
  input logic             s_gain_tready,
  input logic             s_gain_tlast,
  input logic             s_off_tvalid,
  input logic             s_off_tready,
  input logic             s_off_tlast,
  input logic [OUT_W-1:0] m_tdata,
  input logic             m_tvalid,
  input logic             m_tready,
  input logic             m_tlast,
  input logic             m_tuser,
  input logic             tlast_err
);

  // R2
  ready_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pix_tready == s_gain_tready) && (s_pix_tready == s_off_tready));

  // R2
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    s_pix_tready |-> (s_pix_tvalid && s_gain_tvalid && s_off_tvalid));

  // R7
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid && !m_tready) |=> (m_tvalid && $stable(m_tdata) && $stable(m_tlast) && $stable(m_tuser)));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tlast_err |=> tlast_err);

  // R11
  err_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_pix_tvalid && s_pix_tready &&
     ((s_gain_tlast != s_pix_tlast) || (s_off_tlast != s_pix_tlast))) |=> tlast_err);

endmodule

bind twopoint_corrector tpc_checker #(.OUT_W(OUT_W)) i_tpc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .s_pix_tvalid  (s_pix_tvalid),
  .s_pix_tready  (s_pix_tready),
  .s_pix_tlast   (s_pix_tlast),
  .s_gain_tvalid (s_gain_tvalid),
  .s_gain_tready (s_gain_tready),
  .s_gain_tlast  (s_gain_tlast),
  .s_off_tvalid  (s_off_tvalid),
  .s_off_tready  (s_off_tready),
  .s_off_tlast   (s_off_tlast),
  .m_tdata       (m_tdata),
  .m_tvalid      (m_tvalid),
  .m_tready      (m_tready),
  .m_tlast       (m_tlast),
  .m_tuser       (m_tuser),
  .tlast_err     (tlast_err)
);

// File: tb/test_twopoint_corrector.sv
module test_twopoint_corrector;

  localparam int MAXN = 600;
  localparam int LINE = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bypass;
  logic [13:0] s_pix_tdata;
  logic        s_pix_tvalid, s_pix_tready, s_pix_tlast, s_pix_tuser;
  logic [15:0] s_gain_tdata;
  logic        s_gain_tvalid, s_gain_tready, s_gain_tlast;
  logic [15:0] s_off_tdata;
  logic        s_off_tvalid, s_off_tready, s_off_tlast;
  logic [15:0] m_tdata;
  logic        m_tvalid, m_tready, m_tlast, m_tuser;
  logic        tlast_err;

  twopoint_corrector i_twopoint_corrector (
    .clk (clk), .rst_n (rst_n), .bypass (bypass),
    .s_pix_tdata (s_pix_tdata), .s_pix_tvalid (s_pix_tvalid), .s_pix_tready (s_pix_tready),
    .s_pix_tlast (s_pix_tlast), .s_pix_tuser (s_pix_tuser),
    .s_gain_tdata (s_gain_tdata), .s_gain_tvalid (s_gain_tvalid), .s_gain_tready (s_gain_tready),
    .s_gain_tlast (s_gain_tlast),
    .s_off_tdata (s_off_tdata), .s_off_tvalid (s_off_tvalid), .s_off_tready (s_off_tready),
    .s_off_tlast (s_off_tlast),
    .m_tdata (m_tdata), .m_tvalid (m_tvalid), .m_tready (m_tready),
    .m_tlast (m_tlast), .m_tuser (m_tuser), .tlast_err (tlast_err)
  );

  always #4 clk = ~clk;   // 125 MHz

  int n_chk  = 0;
  int n_fail = 0;

  int pix_a [MAXN];
  int gain_a[MAXN];
  int off_a [MAXN];
  bit last_a[MAXN];
  bit user_a[MAXN];
  bit glast_a[MAXN];
  bit olast_a[MAXN];

  typedef struct { int val; bit last; bit user; bit pass; } exp_t;
  exp_t exp_q[$];

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  function automatic int model(input int p, input int g, input int o, input bit pass);
    longint s;
    if (pass) s = p;
    else      s = ((longint'(p) * longint'(g) + 64'sd8192) >>> 14) + o;
    if (s > 32767)  s = 32767;
    if (s < -32768) s = -32768;
    return int'(s);
  endfunction

  task automatic fill(input int n);
    for (int i = 0; i < n; i++) begin
      pix_a[i]  = int'($urandom % 16384);
      gain_a[i] = int'($urandom % 65536);
      off_a[i]  = int'($urandom % 65536) - 32768;
      case (i % 37)
        5: begin pix_a[i] = 16383; gain_a[i] = 65535; off_a[i] = 32767;  end
        6: begin gain_a[i] = 0;    off_a[i] = -32768;                    end
        7: begin pix_a[i] = 1;     gain_a[i] = 8192;  off_a[i] = 0;      end
        8: begin gain_a[i] = 16384; off_a[i] = 0;                        end
        9: begin pix_a[i] = 16383; gain_a[i] = 40000; off_a[i] = 100;    end
        default: ;
      endcase
      last_a[i]  = (i % LINE) == LINE - 1;
      user_a[i]  = (i % (LINE * 4)) == 0;
      glast_a[i] = last_a[i];
      olast_a[i] = last_a[i];
    end
  endtask

  task automatic idle_inputs();
    s_pix_tvalid = 1'b0; s_gain_tvalid = 1'b0; s_off_tvalid = 1'b0;
  endtask

  task automatic run_traffic(input int n, input int vpct, input int rpct,
                             input int bpct, output int stalls);
    int idx = 0;
    int guard = 0;
    bit vp = 1'b0, vg = 1'b0, vo = 1'b0;
    stalls = 0;
    while ((idx < n || exp_q.size() != 0) && guard < 20000) begin
      int j;
      @(negedge clk);
      guard++;
      if (idx < n) begin
        if (!vp) vp = ($urandom % 100) < vpct;
        if (!vg) vg = ($urandom % 100) < vpct;
        if (!vo) vo = ($urandom % 100) < vpct;
      end
      j = (idx < n) ? idx : 0;
      s_pix_tvalid  = vp;  s_pix_tdata  = 14'(pix_a[j]);
      s_pix_tlast   = last_a[j]; s_pix_tuser = user_a[j];
      s_gain_tvalid = vg;  s_gain_tdata = 16'(gain_a[j]); s_gain_tlast = glast_a[j];
      s_off_tvalid  = vo;  s_off_tdata  = 16'(off_a[j]);  s_off_tlast  = olast_a[j];
      bypass   = ($urandom % 100) < bpct;
      m_tready = ($urandom % 100) < rpct;
      #1;
      if (s_pix_tready || s_gain_tready || s_off_tready)
        // R2: all readies together and only with all valids
        check(vp && vg && vo && s_pix_tready && s_gain_tready && s_off_tready,
              "R2", {s_pix_tready, s_gain_tready, s_off_tready}, 7);
      if (s_pix_tready) begin
        exp_t e;
        e.val  = model(pix_a[j], gain_a[j], off_a[j], bypass);
        e.last = last_a[j];
        e.user = user_a[j];
        e.pass = bypass;
        exp_q.push_back(e);
        idx++;
        vp = 1'b0; vg = 1'b0; vo = 1'b0;
      end else if (vp && vg && vo) begin
        stalls++;
      end
      if (m_tvalid && m_tready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6", 1, 0);   // extra output beat
        end else begin
          exp_t e;
          string tag;
          int act;
          e = exp_q.pop_front();
          act = int'($signed(m_tdata));
          tag = e.pass ? "R5" : ((e.val == 32767 || e.val == -32768) ? "R4" : "R3");
          check(act == e.val, tag, act, e.val);
          check({m_tlast, m_tuser} == {e.last, e.user}, "R10",
                int'({m_tlast, m_tuser}), int'({e.last, e.user}));
        end
      end
    end
    // R6: every accepted triple came out
    check(idx == n && exp_q.size() == 0, "R6", exp_q.size(), 0);
    @(negedge clk);
    idle_inputs();
    m_tready = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int stalls;
    void'($urandom(32'd20240611));
    rst_n = 1'b0;
    bypass = 1'b0;
    m_tready = 1'b0;
    s_pix_tdata = '0; s_pix_tlast = 1'b0; s_pix_tuser = 1'b0;
    s_gain_tdata = '0; s_gain_tlast = 1'b0;
    s_off_tdata = '0; s_off_tlast = 1'b0;
    s_pix_tvalid = 1'b1; s_gain_tvalid = 1'b1; s_off_tvalid = 1'b1;

    // R1: reset state with all inputs offering data
    repeat (3) @(negedge clk);
    check(!m_tvalid && !tlast_err, "R1", int'({m_tvalid, tlast_err}), 0);
    check(!s_pix_tready && !s_gain_tready && !s_off_tready, "R1",
          int'({s_pix_tready, s_gain_tready, s_off_tready}), 0);
    idle_inputs();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    check(!m_tvalid && !tlast_err, "R1", int'({m_tvalid, tlast_err}), 0);

    // R9: single beat latency, unit gain
    m_tready = 1'b1;
    s_pix_tdata = 14'd100; s_pix_tlast = 1'b1; s_pix_tuser = 1'b1;
    s_gain_tdata = 16'd16384; s_gain_tlast = 1'b1;
    s_off_tdata = 16'd5; s_off_tlast = 1'b1;
    s_pix_tvalid = 1'b1; s_gain_tvalid = 1'b1; s_off_tvalid = 1'b1;
    #1;
    check(s_pix_tready, "R2", int'(s_pix_tready), 1);
    @(negedge clk); idle_inputs();
    check(!m_tvalid, "R9", int'(m_tvalid), 0);
    @(negedge clk);
    check(!m_tvalid, "R9", int'(m_tvalid), 0);
    @(negedge clk);
    check(m_tvalid && m_tdata == 16'd105, "R9", int'(m_tdata), 105);
    check(m_tlast && m_tuser, "R10", int'({m_tlast, m_tuser}), 3);
    @(negedge clk);
    check(!m_tvalid, "R6", int'(m_tvalid), 0);
    m_tready = 1'b0;

    // R8: full rate, no stalls
    fill(200);
    run_traffic(200, 100, 100, 0, stalls);
    check(stalls == 0, "R8", stalls, 0);

    // R3 R4 R5 R6: random gaps, backpressure, bypass mix
    fill(400);
    run_traffic(400, 60, 50, 30, stalls);
    fill(150);
    run_traffic(150, 90, 15, 50, stalls);
    check(!tlast_err, "R11", int'(tlast_err), 0);

    // R11: flipped gain line marker sets the flag; R10 output marker from pixel
    fill(20);
    glast_a[7] = !last_a[7];
    run_traffic(20, 80, 80, 0, stalls);
    check(tlast_err, "R11", int'(tlast_err), 1);
    fill(30);
    run_traffic(30, 80, 80, 0, stalls);
    check(tlast_err, "R11", int'(tlast_err), 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule